// File: doc/BRIEF.md
# Multi-mode banked scratchpad memory

This block is a local scratchpad for a vector compute unit. Its storage is one SRAM bank per compute lane, so every lane can receive one element in the same cycle. A combinational address unit turns the incoming addresses into a write row, per-bank write enables, per-bank read rows and a lane-to-bank routing choice. How it does this depends on a static banking mode. A small control block decides when a request is accepted. It also holds the FIFO pointers, the line-buffer position and the buffer rotation state.

In the two addressed modes, strided and duplication, the bank rows are split into NBUF buffer slots. A producer fills one slot while a consumer reads another. The slots rotate only after both sides have signalled that they are finished. The FIFO and line-buffer modes are streaming modes: they use slot 0 only and ignore the done signals. Write data goes in one element per cycle. Read data comes out as one element per lane, registered, two cycles after a read is accepted.

The mode is selected on `cfg_mode` (0 strided, 1 FIFO, 2 line buffer, 3 duplication). It may change only while reset is held.

Top module: `multimode_scratchpad`

## Requirements
- R1: After reset, rd_valid is 0, fifo_empty is 1, fifo_full is 0 and rd_ready is 0.
- R2: In strided mode (0), linear address a is stored in bank a mod LANES at row a / LANES of the writer slot. A read with base b in lane field 0 of rd_addr returns the element at linear address (b+i) mod (LANES*DEPTH) on lane i, for any alignment of b.
- R3: In duplication mode (3), a write to address a (low log2(DEPTH) bits) is stored in every bank. Lane i then reads the address in its own field rd_addr[i*ADDR_W +: ADDR_W], independently of the other lanes.
- R4: In FIFO mode (1), elements are returned on lane 0 (bits [DATA_W-1:0]) in the order they were written, across bank boundaries.
- R5: In FIFO mode, fifo_full rises after LANES*DEPTH unread writes. A write while full is discarded and wr_ready is 0. A read while empty produces no rd_valid.
- R6: In line-buffer mode (2), each write appends the next pixel of the current line, and a line holds DEPTH pixels. A read of column c returns, on lane i, column c of the (i+1)-th most recently completed line.
- R7: In the addressed modes, the slots swap when the writer has signalled wr_done and the reader has signalled rd_done, counting each signal from the current rotation onward. The reader counts as done from reset, so the first wr_done alone causes a swap.
- R8: Before the first swap, rd_ready is 0 and reads are not accepted, so no rd_valid follows.
- R9: Writes into the writer slot never change the data returned from the reader slot before the next swap.
- R10: After wr_done and before the swap, wr_ready is 0 and writes are discarded.
- R11: rd_valid is asserted exactly two cycles after the clock edge at which a read was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Banking mode: 0 strided, 1 FIFO, 2 line buffer, 3 duplication |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write address (strided, duplication) |
| wr_data | input | DATA_W | Write data |
| wr_done | input | 1 | Producer has finished filling its slot |
| rd_en | input | 1 | Read request |
| rd_addr | input | LANES*ADDR_W | Per-lane read addresses; lane 0 field is the base or column |
| rd_done | input | 1 | Consumer has finished with its slot |
| rd_data | output | LANES*DATA_W | Registered read data, lane i at [i*DATA_W +: DATA_W] |
| rd_valid | output | 1 | rd_data holds the result of an accepted read |
| rd_ready | output | 1 | A reader slot is available (addressed modes) |
| wr_ready | output | 1 | A write would be accepted in the current mode |
| fifo_full | output | 1 | FIFO holds LANES*DEPTH elements |
| fifo_empty | output | 1 | FIFO holds no elements |

## Verification
The bench sends strided reads at unaligned bases, including one that wraps past the last address. A bad modulo or row carry would return neighbouring or stale elements on the upper lanes. It reads the reader slot while the writer slot is being refilled, and again after a late write that should be blocked. A design that swaps early or lets writes in after done would show the new data or the poison value. In FIFO mode the bench fills the queue to the brim, pushes once more and drains it completely. A wrong full test or pointer wrap would drop or reorder elements at the bank seams. In line-buffer mode it reads after four and after six lines. A wrong lane rotation would give the lines in the wrong order.

// File: rtl/msp_pkg.sv
`timescale 1ns/1ps
package msp_pkg;
  typedef enum logic [1:0] {
    MODE_STRIDED = 2'd0,
    MODE_FIFO    = 2'd1,
    MODE_LINE    = 2'd2,
    MODE_DUP     = 2'd3
  } msp_mode_e;
endpackage

// File: rtl/msp_bank.sv
`timescale 1ns/1ps
module msp_bank #(
  parameter int DATA_W = 16,
  parameter int ROWS   = 16,
  localparam int RB    = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [RB-1:0]     wrow,
  input  logic [DATA_W-1:0] wdata,
  input  logic [RB-1:0]     rrow,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[wrow] <= wdata;
    q <= mem[rrow];
  end
endmodule

// File: rtl/msp_ctrl.sv
`timescale 1ns/1ps
module msp_ctrl
  import msp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int NBUF  = 2,
  localparam int LANE_B = $clog2(LANES),
  localparam int ROW_B  = $clog2(DEPTH),
  localparam int BUF_B  = $clog2(NBUF),
  localparam int PTR_B  = $clog2(LANES*DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  msp_mode_e        mode,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             wr_done,
  input  logic             rd_done,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic [BUF_B-1:0] wbuf,
  output logic [BUF_B-1:0] rbuf,
  output logic [PTR_B-1:0] wptr,
  output logic [PTR_B-1:0] rptr,
  output logic [ROW_B-1:0] lcol,
  output logic [LANE_B-1:0] lline,
  output logic             fifo_full,
  output logic             fifo_empty,
  output logic             rd_ready,
  output logic             wr_ready
);
  logic wdone_q, rdone_q, rvalid_q, buffered, swap;

  assign buffered   = (mode == MODE_STRIDED) || (mode == MODE_DUP);
  assign fifo_empty = (wptr == rptr);
  assign fifo_full  = (wptr[PTR_B-1] != rptr[PTR_B-1]) &&
                      (wptr[PTR_B-2:0] == rptr[PTR_B-2:0]);
  assign rd_ready   = rvalid_q;
  assign swap       = buffered && (wdone_q || wr_done) && (rdone_q || rd_done);

  always_comb begin
    case (mode)
      MODE_FIFO: begin
        wr_ready = !fifo_full;
        rd_fire  = rd_en && !fifo_empty;
      end
      MODE_LINE: begin
        wr_ready = 1'b1;
        rd_fire  = rd_en;
      end
      default: begin
        wr_ready = !wdone_q;
        rd_fire  = rd_en && rvalid_q;
      end
    endcase
    wr_fire = wr_en && wr_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      lcol     <= '0;
      lline    <= '0;
      wbuf     <= '0;
      rbuf     <= '0;
      wdone_q  <= 1'b0;
      rdone_q  <= 1'b1;
      rvalid_q <= 1'b0;
    end else begin
      if (mode == MODE_FIFO) begin
        wptr <= wptr + PTR_B'(wr_fire);
        rptr <= rptr + PTR_B'(rd_fire);
      end
      if (mode == MODE_LINE && wr_fire) begin
        lcol <= lcol + 1'b1;
        if (lcol == ROW_B'(DEPTH-1)) lline <= lline + 1'b1;
      end
      if (swap) begin
        rbuf     <= wbuf;
        wbuf     <= (wbuf == BUF_B'(NBUF-1)) ? '0 : wbuf + 1'b1;
        wdone_q  <= 1'b0;
        rdone_q  <= 1'b0;
        rvalid_q <= 1'b1;
      end else if (buffered) begin
        if (wr_done) wdone_q <= 1'b1;
        if (rd_done) rdone_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/msp_addr.sv
`timescale 1ns/1ps
module msp_addr
  import msp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DEPTH = 8,
  parameter int NBUF  = 2,
  localparam int LANE_B = $clog2(LANES),
  localparam int ROW_B  = $clog2(DEPTH),
  localparam int BUF_B  = $clog2(NBUF),
  localparam int SLOT_B = $clog2(NBUF*DEPTH),
  localparam int ADDR_W = $clog2(LANES*DEPTH),
  localparam int PTR_B  = ADDR_W + 1
) (
  input  msp_mode_e                mode,
  input  logic                     wr_fire,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [LANES*ADDR_W-1:0]  rd_addr,
  input  logic [BUF_B-1:0]         wbuf,
  input  logic [BUF_B-1:0]         rbuf,
  input  logic [PTR_B-1:0]         wptr,
  input  logic [PTR_B-1:0]         rptr,
  input  logic [ROW_B-1:0]         lcol,
  input  logic [LANE_B-1:0]        lline,
  output logic [SLOT_B-1:0]        wrow,
  output logic [LANES-1:0]         bank_we,
  output logic [LANES*SLOT_B-1:0]  rrow,
  output logic [LANES*LANE_B-1:0]  lane_sel
);
  logic [ADDR_W-1:0] base;
  assign base = rd_addr[ADDR_W-1:0];

  function automatic logic [SLOT_B-1:0] slot_off(input logic [BUF_B-1:0] b);
    return SLOT_B'(b) * SLOT_B'(DEPTH);
  endfunction

  always_comb begin
    wrow     = '0;
    bank_we  = '0;
    rrow     = '0;
    lane_sel = '0;
    case (mode)
      MODE_STRIDED: begin
        wrow = slot_off(wbuf) + SLOT_B'(wr_addr >> LANE_B);
        for (int b = 0; b < LANES; b++) begin
          bank_we[b] = wr_fire && (wr_addr[LANE_B-1:0] == LANE_B'(b));
          rrow[b*SLOT_B +: SLOT_B] = slot_off(rbuf) + SLOT_B'(
            (base + ADDR_W'(LANE_B'(LANE_B'(b) - base[LANE_B-1:0]))) >> LANE_B);
          lane_sel[b*LANE_B +: LANE_B] = base[LANE_B-1:0] + LANE_B'(b);
        end
      end
      MODE_FIFO: begin
        wrow = SLOT_B'(wptr[PTR_B-2:LANE_B]);
        for (int b = 0; b < LANES; b++) begin
          bank_we[b] = wr_fire && (wptr[LANE_B-1:0] == LANE_B'(b));
          rrow[b*SLOT_B +: SLOT_B]     = SLOT_B'(rptr[PTR_B-2:LANE_B]);
          lane_sel[b*LANE_B +: LANE_B] = rptr[LANE_B-1:0];
        end
      end
      MODE_LINE: begin
        wrow = SLOT_B'(lcol);
        for (int b = 0; b < LANES; b++) begin
          bank_we[b] = wr_fire && (lline == LANE_B'(b));
          rrow[b*SLOT_B +: SLOT_B]     = SLOT_B'(base[ROW_B-1:0]);
          lane_sel[b*LANE_B +: LANE_B] = lline - LANE_B'(1) - LANE_B'(b);
        end
      end
      default: begin
        wrow = slot_off(wbuf) + SLOT_B'(wr_addr[ROW_B-1:0]);
        for (int b = 0; b < LANES; b++) begin
          bank_we[b] = wr_fire;
          rrow[b*SLOT_B +: SLOT_B] = slot_off(rbuf) +
                                     SLOT_B'(rd_addr[b*ADDR_W +: ROW_B]);
          lane_sel[b*LANE_B +: LANE_B] = LANE_B'(b);
        end
      end
    endcase
  end
endmodule

// File: rtl/multimode_scratchpad.sv
`timescale 1ns/1ps
module multimode_scratchpad
  import msp_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int DEPTH  = 8,
  parameter int NBUF   = 2,
  parameter int DATA_W = 16,
  localparam int LANE_B = $clog2(LANES),
  localparam int ROW_B  = $clog2(DEPTH),
  localparam int BUF_B  = $clog2(NBUF),
  localparam int SLOT_B = $clog2(NBUF*DEPTH),
  localparam int ADDR_W = $clog2(LANES*DEPTH),
  localparam int PTR_B  = ADDR_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               cfg_mode,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_done,
  input  logic                     rd_en,
  input  logic [LANES*ADDR_W-1:0]  rd_addr,
  input  logic                     rd_done,
  output logic [LANES*DATA_W-1:0]  rd_data,
  output logic                     rd_valid,
  output logic                     rd_ready,
  output logic                     wr_ready,
  output logic                     fifo_full,
  output logic                     fifo_empty
);
  msp_mode_e mode;
  assign mode = msp_mode_e'(cfg_mode);

  logic                    wr_fire, rd_fire;
  logic [BUF_B-1:0]        wbuf, rbuf;
  logic [PTR_B-1:0]        wptr, rptr;
  logic [ROW_B-1:0]        lcol;
  logic [LANE_B-1:0]       lline;
  logic [SLOT_B-1:0]       wrow;
  logic [LANES-1:0]        bank_we;
  logic [LANES*SLOT_B-1:0] rrow;
  logic [LANES*LANE_B-1:0] lane_sel, sel_q;
  logic [DATA_W-1:0]       bank_q [LANES];
  logic                    v1_q;

  msp_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .NBUF(NBUF)) ctrl_i (
    .clk(clk), .rst(rst), .mode(mode), .wr_en(wr_en), .rd_en(rd_en),
    .wr_done(wr_done), .rd_done(rd_done), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wbuf(wbuf), .rbuf(rbuf), .wptr(wptr), .rptr(rptr), .lcol(lcol),
    .lline(lline), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .rd_ready(rd_ready), .wr_ready(wr_ready)
  );

  msp_addr #(.LANES(LANES), .DEPTH(DEPTH), .NBUF(NBUF)) addr_i (
    .mode(mode), .wr_fire(wr_fire), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .wbuf(wbuf), .rbuf(rbuf), .wptr(wptr), .rptr(rptr), .lcol(lcol),
    .lline(lline), .wrow(wrow), .bank_we(bank_we), .rrow(rrow),
    .lane_sel(lane_sel)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    msp_bank #(.DATA_W(DATA_W), .ROWS(NBUF*DEPTH)) bank_i (
      .clk(clk), .we(bank_we[g]), .wrow(wrow), .wdata(wr_data),
      .rrow(rrow[g*SLOT_B +: SLOT_B]), .q(bank_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q     <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      v1_q     <= rd_fire;
      rd_valid <= v1_q;
    end
    if (rd_fire) sel_q <= lane_sel;
    if (v1_q) begin
      for (int i = 0; i < LANES; i++)
        rd_data[i*DATA_W +: DATA_W] <= bank_q[sel_q[i*LANE_B +: LANE_B]];
    end
  end
endmodule

// File: rtl/msp_chk.sv
`timescale 1ns/1ps
module msp_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cfg_mode,
  input logic       wr_en,
  input logic       rd_en,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic       fifo_full,
  input logic       fifo_empty
);
  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd1 && fifo_full && wr_en && !rd_en) |=> fifo_full);

  // R5
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_mode == 2'd1 && fifo_empty && rd_en && !wr_en) |=> fifo_empty);

  // R11
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en, 2));

  // R8
  rd_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ((cfg_mode == 2'd0 || cfg_mode == 2'd3) && rd_valid) |-> $past(rd_ready, 2));

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    rd_ready |=> rd_ready);
endmodule

bind multimode_scratchpad msp_chk chk_i (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .wr_en(wr_en), .rd_en(rd_en),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty)
);

// File: tb/multimode_scratchpad_tb_top.sv
`timescale 1ns/1ps
module multimode_scratchpad_tb_top;
  localparam int L = 4, D = 8, NB = 2, DW = 16, AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cfg_mode = 2'd0;
  logic          wr_en = 1'b0, wr_done = 1'b0, rd_en = 1'b0, rd_done = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [L*AW-1:0] rd_addr = '0;
  logic [L*DW-1:0] rd_data;
  logic rd_valid, rd_ready, wr_ready, fifo_full, fifo_empty;

  multimode_scratchpad #(.LANES(L), .DEPTH(D), .NBUF(NB), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_done(wr_done), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .wr_ready(wr_ready), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty)
  );

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;
  logic [L*DW-1:0] exp_q[$], mask_q[$];
  int              due_q[$];
  string           tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever the design presents a result
  always @(posedge clk) begin
    #2;
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R8/R5 unexpected rd_valid", 64'(rd_data), 64'd0);
      end else begin
        logic [L*DW-1:0] e, m;
        int   due;
        string t;
        e = exp_q.pop_front(); m = mask_q.pop_front();
        due = due_q.pop_front(); t = tag_q.pop_front();
        chk((rd_data & m) == (e & m), t, 64'(rd_data & m), 64'(e & m));
        chk(cyc == due, "R11 latency", 64'(cyc), 64'(due));
      end
    end
  end

  task automatic reset_to(input logic [1:0] m);
    rst = 1'b1; cfg_mode = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_done(input bit w, input bit r);
    wr_done = w; rd_done = r;
    @(negedge clk);
    wr_done = 1'b0; rd_done = 1'b0;
  endtask

  task automatic do_read(input logic [L*AW-1:0] a, input bit accept,
                         input logic [L*DW-1:0] e, input logic [L*DW-1:0] m,
                         input string tag);
    rd_en = 1'b1; rd_addr = a;
    if (accept) begin
      exp_q.push_back(e); mask_q.push_back(m);
      due_q.push_back(cyc + 2); tag_q.push_back(tag);
    end
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [L*DW-1:0] strided_exp(input int b, input int pre);
    logic [L*DW-1:0] v;
    for (int i = 0; i < L; i++) v[i*DW +: DW] = DW'(pre + ((b + i) % (L*D)));
    return v;
  endfunction

  function automatic logic [L*DW-1:0] line_exp(input int newest, input int col);
    logic [L*DW-1:0] v;
    for (int i = 0; i < L; i++) v[i*DW +: DW] = DW'(16'h5000 + (newest - i) * 16 + col);
    return v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [L*DW-1:0] ALL  = '1;
  localparam logic [L*DW-1:0] LAN0 = {{(L-1)*DW{1'b0}}, {DW{1'b1}}};

  initial begin
    // ---------- strided mode with double buffering ----------
    reset_to(2'd0);
    chk(rd_valid == 0, "R1 rd_valid", 64'(rd_valid), 0);
    chk(fifo_empty == 1, "R1 fifo_empty", 64'(fifo_empty), 1);
    chk(fifo_full == 0, "R1 fifo_full", 64'(fifo_full), 0);
    chk(rd_ready == 0, "R1 rd_ready", 64'(rd_ready), 0);
    do_read('0, 0, '0, '0, "R8 blocked");
    repeat (3) @(negedge clk);
    chk(rd_valid == 0, "R8 no data before swap", 64'(rd_valid), 0);
    for (int a = 0; a < L*D; a++) do_write(AW'(a), DW'(16'h1000 + a));
    pulse_done(1, 0);
    chk(rd_ready == 1, "R7 first swap", 64'(rd_ready), 1);
    do_read(20'd0,  1, strided_exp(0, 16'h1000),  ALL, "R2 base 0");
    do_read(20'd4,  1, strided_exp(4, 16'h1000),  ALL, "R2 base 4");
    do_read(20'd6,  1, strided_exp(6, 16'h1000),  ALL, "R2 base 6 unaligned");
    do_read(20'd30, 1, strided_exp(30, 16'h1000), ALL, "R2 base 30 wrap");
    for (int a = 0; a < L*D; a++) do_write(AW'(a), DW'(16'h2000 + a));
    do_read(20'd5, 1, strided_exp(5, 16'h1000), ALL, "R9 reader slot isolated");
    pulse_done(1, 0);
    chk(wr_ready == 0, "R10 wr_ready after done", 64'(wr_ready), 0);
    chk(rd_ready == 1, "R7 no swap without rd_done", 64'(rd_ready), 1);
    do_write(AW'(0), 16'hDEAD);
    do_read(20'd0, 1, strided_exp(0, 16'h1000), ALL, "R7 still old slot");
    pulse_done(0, 1);
    chk(wr_ready == 1, "R7 writer released", 64'(wr_ready), 1);
    do_read(20'd0, 1, strided_exp(0, 16'h2000), ALL, "R10 late write dropped");
    do_read(20'd3, 1, strided_exp(3, 16'h2000), ALL, "R7 new slot base 3");
    repeat (4) @(negedge clk);

    // ---------- duplication mode ----------
    reset_to(2'd3);
    for (int a = 0; a < D; a++) do_write(AW'(a), DW'(16'h3000 + 3*a));
    pulse_done(1, 0);
    do_read({5'd3, 5'd3, 5'd0, 5'd7}, 1,
            {16'h3009, 16'h3009, 16'h3000, 16'h3015}, ALL, "R3 gather 7/0/3/3");
    do_read({5'd6, 5'd4, 5'd2, 5'd1}, 1,
            {16'h3012, 16'h300C, 16'h3006, 16'h3003}, ALL, "R3 gather 1/2/4/6");
    repeat (4) @(negedge clk);

    // ---------- FIFO mode ----------
    reset_to(2'd1);
    chk(fifo_empty == 1 && fifo_full == 0, "R5 fifo starts empty",
        64'({fifo_full, fifo_empty}), 64'(2'b01));
    for (int k = 0; k < L*D; k++) do_write('0, DW'(16'h4000 + k));
    chk(fifo_full == 1, "R5 full after LANES*DEPTH", 64'(fifo_full), 1);
    chk(wr_ready == 0, "R5 wr_ready when full", 64'(wr_ready), 0);
    do_write('0, 16'hBEEF);
    for (int k = 0; k < L*D; k++)
      do_read('0, 1, (L*DW)'(16'h4000 + k), LAN0, "R4 fifo order");
    chk(fifo_empty == 1, "R5 empty after drain", 64'(fifo_empty), 1);
    do_read('0, 0, '0, '0, "R5 read when empty");
    repeat (4) @(negedge clk);
    chk(fifo_empty == 1, "R5 overflow write discarded", 64'(fifo_empty), 1);

    // ---------- line buffer mode ----------
    reset_to(2'd2);
    for (int ln = 0; ln < 4; ln++)
      for (int c = 0; c < D; c++) do_write('0, DW'(16'h5000 + ln*16 + c));
    do_read(20'd2, 1, line_exp(3, 2), ALL, "R6 window after 4 lines");
    for (int ln = 4; ln < 6; ln++)
      for (int c = 0; c < D; c++) do_write('0, DW'(16'h5000 + ln*16 + c));
    do_read(20'd5, 1, line_exp(5, 5), ALL, "R6 window after 6 lines");
    do_read(20'd7, 1, line_exp(5, 7), ALL, "R6 last column");
    repeat (4) @(negedge clk);

    chk(exp_q.size() == 0, "R11 all results returned", 64'(exp_q.size()), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule